// File: doc/BRIEF.md
# Packet Client Control and Statistics Registers

This block is the control and statistics register file that sits beside a hardware packet generator. Software starts the generator with a single control write. One other write encoding stops it and zeroes every statistic. The generator reports the end of its burst through `burst_done`. The block counts six kinds of traffic events: start of packet, end of packet and error, each for the transmit side and for the receive side. Each count is held in a saturating counter of `CNT_W` bits and is read as a low and a high 32-bit word.

Wide counters cannot be read in one bus access. A snapshot bit in the control register solves this. When the bit rises, all six live counts are copied into shadow registers in one clock. Reads then return the frozen copy while the live counters keep counting. Clearing the bit returns reads to the live values. The traffic counts match the sent burst when traffic is looped back: a burst of 16 packets reads back 16 starts and 16 ends on both sides.

Two state machines set the behaviour:
- Generator machine. States `GEN_IDLE` and `GEN_RUN`. Transitions:
  - `GEN_IDLE -> GEN_RUN` on a start write.
  - `GEN_RUN -> GEN_IDLE` on a stop/clear write or on `burst_done`.
- Snapshot machine. States `SNAP_LIVE` and `SNAP_FROZEN`. Transitions:
  - `SNAP_LIVE -> SNAP_FROZEN` on a control write with bit 6 set. This transition copies the counts.
  - `SNAP_FROZEN -> SNAP_LIVE` on a control write with bit 6 clear.

Top module: `pkt_client_csr`

## Requirements
- R1: A write to byte offset 0x00 with bit 0 set moves the generator to the running state. `gen_run` is 1 from the clock edge that takes the write. Reading offset 0x00 returns the running state in bit 0 and the snapshot bit in bit 6, with all other bits 0.
- R2: A write to offset 0x00 whose bits [2:0] equal 3'b100 stops the generator (`gen_run` goes to 0) and sets all six live counters to zero at the same edge.
- R3: While the generator is running, a `burst_done` pulse returns it to idle. A start write in the same cycle as `burst_done` keeps it running.
- R4: Each counter is read as two words, low word first. The offsets are:

  | Counter | Low word | High word |
  |---|---|---|
  | transmit start | 0x20 | 0x24 |
  | transmit end | 0x28 | 0x2C |
  | transmit error | 0x30 | 0x34 |
  | receive start | 0x38 | 0x3C |
  | receive end | 0x40 | 0x44 |
  | receive error | 0x48 | 0x4C |

  Bits above `CNT_W` read as 0.
- R5: Each event input that is 1 in a clock cycle adds exactly one to its own counter. Events on different inputs in the same cycle are all counted.
- R6: A live counter that holds the all-ones value of `CNT_W` bits stays at that value when further events arrive. It does not wrap.
- R7: A control write that changes bit 6 from 0 to 1 copies all six live counts, as they stood before that cycle's events, into shadow registers. While bit 6 stays 1:
  - counter reads return the shadow values;
  - the shadow values do not change;
  - the live counters keep counting.
- R8: A control write with bit 6 clear ends the snapshot. Later counter reads return the live values.
- R9: When a stop/clear write and an event fall in the same cycle, the counter reads zero afterwards.
- R10: Reads of offsets that are not defined return zero. Undefined offsets are those not word-aligned, 0x04 to 0x1C, and above 0x4C. Writes to any offset other than 0x00 have no effect on any counter.
- R11: `csr_rd_data` and `csr_rd_valid` are registered. `csr_rd_valid` is 1 in exactly the cycle after a cycle with `csr_rd` high.
- R12: After reset the generator is idle, the snapshot bit is 0 and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wr_addr | input | ADDR_W | Write byte offset |
| csr_wr_data | input | 32 | Write data |
| csr_rd | input | 1 | Register read strobe |
| csr_rd_addr | input | ADDR_W | Read byte offset |
| csr_rd_data | output | 32 | Read data, one cycle after the strobe |
| csr_rd_valid | output | 1 | Read data valid |
| tx_sop_evt | input | 1 | Transmit start-of-packet event |
| tx_eop_evt | input | 1 | Transmit end-of-packet event |
| tx_err_evt | input | 1 | Transmit error event |
| rx_sop_evt | input | 1 | Receive start-of-packet event |
| rx_eop_evt | input | 1 | Receive end-of-packet event |
| rx_err_evt | input | 1 | Receive error event |
| burst_done | input | 1 | Generator finished its burst |
| gen_run | output | 1 | Generator run enable |

## Verification
The assertions assume the following about the inputs:
- Reads and writes are one-cycle strobes with stable addresses.
- An event input that is high counts once for each cycle it stays high.
- No counter is expected to pass its all-ones value except through saturation.

The stimulus drives every strobe and event for exactly one clock, between falling edges. It never opens a snapshot in the same cycle as an event. A second instance with five-bit counters takes the same inputs, so that saturation is reached within a few dozen events.

// File: rtl/pkt_client_pkg.sv
package pkt_client_pkg;
    localparam int NUM_EVT  = 6;
    localparam int CTRL_OFS = 'h00;
    localparam int CNT_BASE = 'h20;
    localparam int CNT_LAST = 'h4C;
    localparam int START_BIT = 0;
    localparam int SNAP_BIT  = 6;
    localparam logic [2:0] STOP_CLR_CODE = 3'b100;

    typedef enum logic {GEN_IDLE, GEN_RUN} gen_state_t;
    typedef enum logic {SNAP_LIVE, SNAP_FROZEN} snap_state_t;
endpackage

// File: rtl/pkt_client_ctrl.sv
module pkt_client_ctrl
    import pkt_client_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    input  logic        burst_done,
    output logic        gen_run,
    output logic        snap_on,
    output logic        snap_take,
    output logic        clr_pulse
);
    gen_state_t  gen_q, gen_d;
    snap_state_t snap_q, snap_d;

    logic start_req;
    logic stop_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q  <= GEN_IDLE;
            snap_q <= SNAP_LIVE;
        end else begin
            gen_q  <= gen_d;
            snap_q <= snap_d;
        end
    end

    always_comb begin
        start_req = ctrl_wr && ctrl_wdata[START_BIT];
        stop_req  = ctrl_wr && (ctrl_wdata[2:0] == STOP_CLR_CODE);
        gen_d     = gen_q;
        snap_d    = snap_q;
        snap_take = 1'b0;
        clr_pulse = stop_req;

        unique case (gen_q)
            GEN_IDLE: if (start_req) gen_d = GEN_RUN;
            GEN_RUN: begin
                if (stop_req)        gen_d = GEN_IDLE;
                else if (start_req)  gen_d = GEN_RUN;
                else if (burst_done) gen_d = GEN_IDLE;
            end
            default: gen_d = GEN_IDLE;
        endcase

        unique case (snap_q)
            SNAP_LIVE: if (ctrl_wr && ctrl_wdata[SNAP_BIT]) begin
                snap_d    = SNAP_FROZEN;
                snap_take = 1'b1;
            end
            SNAP_FROZEN: if (ctrl_wr && !ctrl_wdata[SNAP_BIT]) snap_d = SNAP_LIVE;
            default: snap_d = SNAP_LIVE;
        endcase

        gen_run = (gen_q == GEN_RUN);
        snap_on = (snap_q == SNAP_FROZEN);
    end
endmodule

// File: rtl/pkt_sat_counter.sv
module pkt_sat_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt <= '0;
        else if (clr)                 cnt <= '0;
        else if (inc && cnt != TOP)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pkt_client_csr.sv
module pkt_client_csr
    import pkt_client_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [ADDR_W-1:0] csr_wr_addr,
    input  logic [31:0]       csr_wr_data,
    input  logic              csr_rd,
    input  logic [ADDR_W-1:0] csr_rd_addr,
    output logic [31:0]       csr_rd_data,
    output logic              csr_rd_valid,
    input  logic              tx_sop_evt,
    input  logic              tx_eop_evt,
    input  logic              tx_err_evt,
    input  logic              rx_sop_evt,
    input  logic              rx_eop_evt,
    input  logic              rx_err_evt,
    input  logic              burst_done,
    output logic              gen_run
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CNT_BASE);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(CNT_LAST);

    logic ctrl_wr, snap_on, snap_take, clr_pulse;
    assign ctrl_wr = csr_wr && (csr_wr_addr == A_CTRL);

    pkt_client_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (csr_wr_data),
        .burst_done (burst_done),
        .gen_run    (gen_run),
        .snap_on    (snap_on),
        .snap_take  (snap_take),
        .clr_pulse  (clr_pulse)
    );

    logic [NUM_EVT-1:0] evt;
    assign evt = {rx_err_evt, rx_eop_evt, rx_sop_evt, tx_err_evt, tx_eop_evt, tx_sop_evt};

    logic [CNT_W-1:0] live_cnt [NUM_EVT];
    logic [CNT_W-1:0] shot_cnt [NUM_EVT];

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        pkt_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_pulse),
            .inc   (evt[g]),
            .cnt   (live_cnt[g])
        );
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         shot_cnt[g] <= '0;
            else if (snap_take) shot_cnt[g] <= live_cnt[g];
        end
    end

    logic [CNT_W-1:0] live_tx_sop, shot_tx_sop;
    assign live_tx_sop = live_cnt[0];
    assign shot_tx_sop = shot_cnt[0];

    logic              hit_ctrl, hit_cnt, hi_word;
    logic [ADDR_W-1:0] rel;
    logic [2:0]        idx;
    logic [CNT_W-1:0]  sel;
    logic [63:0]       wide;
    logic [31:0]       rd_next;

    always_comb begin
        rel      = csr_rd_addr - A_BASE;
        hit_ctrl = (csr_rd_addr == A_CTRL);
        hit_cnt  = (csr_rd_addr[1:0] == 2'b00) && (csr_rd_addr >= A_BASE) && (csr_rd_addr <= A_LAST);
        idx      = hit_cnt ? rel[5:3] : 3'd0;
        hi_word  = rel[2];
        sel      = snap_on ? shot_cnt[idx] : live_cnt[idx];
        wide     = 64'(sel);
        if (hit_ctrl)
            rd_next = {25'd0, snap_on, 5'd0, gen_run};
        else if (hit_cnt)
            rd_next = hi_word ? wide[63:32] : wide[31:0];
        else
            rd_next = 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_rd_data  <= '0;
            csr_rd_valid <= 1'b0;
        end else begin
            csr_rd_valid <= csr_rd;
            if (csr_rd) csr_rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/pkt_client_csr_chk.sv
module pkt_client_csr_chk #(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_wr,
    input logic [ADDR_W-1:0] csr_wr_addr,
    input logic [31:0]       csr_wr_data,
    input logic              csr_rd,
    input logic [ADDR_W-1:0] csr_rd_addr,
    input logic [31:0]       csr_rd_data,
    input logic              csr_rd_valid,
    input logic              burst_done,
    input logic              gen_run,
    input logic              snap_on,
    input logic [CNT_W-1:0]  live_tx_sop,
    input logic [CNT_W-1:0]  shot_tx_sop
);
    logic ctl_w, start_w, stop_w, undef_rd;
    assign ctl_w    = csr_wr && (csr_wr_addr == '0);
    assign start_w  = ctl_w && csr_wr_data[0];
    assign stop_w   = ctl_w && (csr_wr_data[2:0] == 3'b100);
    assign undef_rd = csr_rd && ((csr_rd_addr[1:0] != 2'b00) ||
                      ((csr_rd_addr != '0) && ((csr_rd_addr < ADDR_W'('h20)) || (csr_rd_addr > ADDR_W'('h4C)))));

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> gen_run);

    assert_stop_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> (!gen_run && live_tx_sop == '0));

    assert_burst_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_run && burst_done && !start_w) |=> !gen_run);

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_w |=> (live_tx_sop >= $past(live_tx_sop)));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_on && !ctl_w) |=> $stable(shot_tx_sop));

    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        undef_rd |=> (csr_rd_data == 32'd0));

    assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |=> csr_rd_valid);

    assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |=> !csr_rd_valid);
endmodule

bind pkt_client_csr pkt_client_csr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_wr       (csr_wr),
    .csr_wr_addr  (csr_wr_addr),
    .csr_wr_data  (csr_wr_data),
    .csr_rd       (csr_rd),
    .csr_rd_addr  (csr_rd_addr),
    .csr_rd_data  (csr_rd_data),
    .csr_rd_valid (csr_rd_valid),
    .burst_done   (burst_done),
    .gen_run      (gen_run),
    .snap_on      (snap_on),
    .live_tx_sop  (live_tx_sop),
    .shot_tx_sop  (shot_tx_sop)
);

// File: tb/pkt_client_csr_test.sv
module pkt_client_csr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_wr = 1'b0, csr_rd = 1'b0;
    logic [7:0] csr_wr_addr = '0, csr_rd_addr = '0;
    logic [31:0] csr_wr_data = '0;
    logic tx_sop_evt = 0, tx_eop_evt = 0, tx_err_evt = 0;
    logic rx_sop_evt = 0, rx_eop_evt = 0, rx_err_evt = 0;
    logic burst_done = 0;
    logic [31:0] csr_rd_data, rd_data_s;
    logic csr_rd_valid, rd_valid_s, gen_run, gen_run_s;

    always #4 clk = ~clk;

    pkt_client_csr uut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wr_addr(csr_wr_addr),
        .csr_wr_data(csr_wr_data), .csr_rd(csr_rd), .csr_rd_addr(csr_rd_addr),
        .csr_rd_data(csr_rd_data), .csr_rd_valid(csr_rd_valid),
        .tx_sop_evt(tx_sop_evt), .tx_eop_evt(tx_eop_evt), .tx_err_evt(tx_err_evt),
        .rx_sop_evt(rx_sop_evt), .rx_eop_evt(rx_eop_evt), .rx_err_evt(rx_err_evt),
        .burst_done(burst_done), .gen_run(gen_run));

    pkt_client_csr #(.CNT_W(5)) uut_small (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wr_addr(csr_wr_addr),
        .csr_wr_data(csr_wr_data), .csr_rd(csr_rd), .csr_rd_addr(csr_rd_addr),
        .csr_rd_data(rd_data_s), .csr_rd_valid(rd_valid_s),
        .tx_sop_evt(tx_sop_evt), .tx_eop_evt(tx_eop_evt), .tx_err_evt(tx_err_evt),
        .rx_sop_evt(rx_sop_evt), .rx_eop_evt(rx_eop_evt), .rx_err_evt(rx_err_evt),
        .burst_done(burst_done), .gen_run(gen_run_s));

    typedef struct {
        logic [31:0] exp;
        logic [31:0] exp_s;
        bit          chk_s;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each returned read with the queued expectation
    always @(negedge clk) begin
        if (rst_n && csr_rd_valid) begin
            if (q.size() == 0) check(1'b0, "R11 unexpected read data", csr_rd_data, 32'd0);
            else begin
                item_t it;
                it = q.pop_front();
                check(csr_rd_data == it.exp, it.tag, csr_rd_data, it.exp);
                if (it.chk_s) check(rd_data_s == it.exp_s, {it.tag, " small"}, rd_data_s, it.exp_s);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag,
                      input bit cs = 0, input logic [31:0] es = 0);
        item_t it;
        it.exp = e; it.exp_s = es; it.chk_s = cs; it.tag = tag;
        @(negedge clk);
        csr_rd = 1'b1; csr_rd_addr = a;
        q.push_back(it);
        @(negedge clk);
        csr_rd = 1'b0;
        @(negedge clk);
        check(!csr_rd_valid, "R11 valid lasts one cycle", 32'(csr_rd_valid), 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_wr_addr = a; csr_wr_data = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        {rx_err_evt, rx_eop_evt, rx_sop_evt, tx_err_evt, tx_eop_evt, tx_sop_evt} = m;
        @(negedge clk);
        {rx_err_evt, rx_eop_evt, rx_sop_evt, tx_err_evt, tx_eop_evt, tx_sop_evt} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(gen_run == 1'b0, "R12 idle after reset", 32'(gen_run), 0);
        rd(8'h00, 32'h0, "R12 control reads zero");
        rd(8'h20, 32'h0, "R12 counter reads zero");

        wr(8'h00, 32'h1);
        check(gen_run == 1'b1, "R1 start", 32'(gen_run), 1);
        rd(8'h00, 32'h1, "R1 control shows running");

        for (int i = 0; i < 16; i++) begin
            pulse(6'b001_001);
            pulse(6'b010_010);
        end
        pulse(6'b000_100); pulse(6'b000_100);
        pulse(6'b100_000); pulse(6'b100_000); pulse(6'b100_000);
        @(negedge clk); burst_done = 1'b1;
        @(negedge clk); burst_done = 1'b0;
        check(gen_run == 1'b0, "R3 burst end stops generator", 32'(gen_run), 0);

        rd(8'h20, 32'd16, "R4 R5 tx sop low", 1, 32'd16);
        rd(8'h24, 32'd0,  "R4 tx sop high");
        rd(8'h28, 32'd16, "R4 R5 tx eop low");
        rd(8'h30, 32'd2,  "R4 R5 tx err low");
        rd(8'h38, 32'd16, "R4 R5 rx sop low");
        rd(8'h40, 32'd16, "R4 R5 rx eop low");
        rd(8'h48, 32'd3,  "R4 R5 rx err low");
        rd(8'h4C, 32'd0,  "R4 rx err high");

        wr(8'h00, 32'h40);
        repeat (5) pulse(6'b000_001);
        rd(8'h20, 32'd16, "R7 snapshot frozen");
        rd(8'h00, 32'h40, "R7 control shows snapshot");
        wr(8'h00, 32'h0);
        rd(8'h20, 32'd21, "R8 live after snapshot");

        rd(8'h04, 32'd0, "R10 undefined 0x04");
        rd(8'h50, 32'd0, "R10 undefined 0x50");
        rd(8'h22, 32'd0, "R10 unaligned 0x22");
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'd21, "R10 counter write ignored");

        wr(8'h00, 32'h1);
        check(gen_run == 1'b1, "R1 restart", 32'(gen_run), 1);
        @(negedge clk);
        csr_wr = 1'b1; csr_wr_addr = 8'h00; csr_wr_data = 32'h4; tx_sop_evt = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0; tx_sop_evt = 1'b0;
        check(gen_run == 1'b0, "R2 stop", 32'(gen_run), 0);
        rd(8'h20, 32'd0, "R9 clear beats event");
        rd(8'h48, 32'd0, "R2 rx err cleared");

        repeat (40) pulse(6'b100_000);
        rd(8'h48, 32'd40, "R6 saturation low", 1, 32'd31);
        rd(8'h4C, 32'd0,  "R6 saturation high", 1, 32'd0);

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R11 all reads returned", 32'(q.size()), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule